// File: doc/BRIEF.md
# Multi-Source Interrupt Collector

This block gathers interrupt requests from up to twelve coprocessors and presents them to a host CPU as one combined interrupt line. Each coprocessor drives an active-low request pin. The block samples every pin through a two-flop synchronizer and watches for a falling edge. An edge latches a sticky bit in that source's position of a flag register.

The host drives a small register bus. It reads the flag register to learn which sources need service, then writes ones to clear the bits it has handled. Requests can keep arriving while the host is clearing. A request that lands in the same cycle as a clear of its own bit is kept. A mask register selects which flags may raise the host line. A third register drives one reset output per coprocessor, so the host can restart each coprocessor on its own, apart from the global reset.

Top module: `irq_aggregator`

## Requirements
- R1: While `rst_n` is low, and on its release, the flag, mask and reset-control registers are all zero and `host_irq` is low. This holds for a reset asserted in mid-run as well.
- R2: A high-to-low transition on `src_irq_n[i]` sets flag bit i. Bit i is visible at offset 0 after the third rising clock edge following the transition. Several sources falling together set all of their bits.
- R3: A write to offset 0 clears each flag bit whose data bit is 1 and leaves the bits whose data bit is 0 unchanged.
- R4: A new request for a source that arrives in the same cycle as a clear of that source's bit leaves the bit set. Other bits named in the same write are still cleared.
- R5: `host_irq` is high exactly when some flag bit is set and its mask bit at offset 1 is 1. It follows register changes without an extra register stage.
- R6: Offset 1 holds the 12-bit mask. The mask reads back as it was written.
- R7: Offset 2 holds the per-source reset control. Bit i drives `src_rst[i]` directly, and the value reads back as written.
- R8: Offset 3 reads as zero. A write to offset 3 changes no register.
- R9: A source held low after its flag was cleared does not set the flag again. Only a new falling edge sets it.
- R10: A low-to-high transition on a source input does not set its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Global asynchronous reset, active low |
| src_irq_n | input | NUM_SRC | Request pins from the coprocessors, active low, asynchronous |
| bus_wr | input | 1 | Write strobe, one write per cycle in which it is high |
| bus_addr | input | 2 | Register offset: 0 flags, 1 mask, 2 reset control, 3 unused |
| bus_wdata | input | NUM_SRC | Write data |
| bus_rdata | output | NUM_SRC | Read data for `bus_addr`, combinational |
| host_irq | output | 1 | Combined interrupt to the host, active high |
| src_rst | output | NUM_SRC | Per-source reset outputs, active high |

## Verification
The hardest case to reach is the collision of a new falling edge with a write-one-to-clear of the same bit. The edge only reaches the flag logic three clocks after the pin moves, so the write has to be lined up with that delay. The stimulus first sets one flag and restores its input to high. It then drops that input and issues a clear on the second falling clock edge afterwards, so the write strobe spans the rising edge on which the new request lands. The same write also names a second, already-set bit, which must be cleared.

// File: rtl/irq_agg_pkg.sv
`timescale 1ns/1ps
package irq_agg_pkg;

    localparam int REG_AW = 2;

    typedef enum logic [REG_AW-1:0] {
        SEL_FLAGS = 2'd0,
        SEL_MASK  = 2'd1,
        SEL_RSTC  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/irq_agg_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer per source plus falling-edge detector.
module irq_agg_sync #(
    parameter int NUM_SRC = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_n_i,
    output logic [NUM_SRC-1:0] fall_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] meta;
        logic [NUM_SRC-1:0] sync;
        logic [NUM_SRC-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = req_n_i;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.meta <= '1;
            st_q.sync <= '1;
            st_q.prev <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_edge
        assign fall_o[g] = st_q.prev[g] & ~st_q.sync[g];
    end

endmodule

// File: rtl/irq_agg_flags.sv
`timescale 1ns/1ps
// Sticky flag bank: set beats clear in the same cycle.
module irq_agg_flags #(
    parameter int NUM_SRC = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] flags_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] flags;
    } flag_t;

    flag_t fl_d, fl_q;

    always_comb begin
        fl_d       = fl_q;
        fl_d.flags = (fl_q.flags & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q.flags <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign flags_o = fl_q.flags;

endmodule

// File: rtl/irq_agg_regs.sv
`timescale 1ns/1ps
// Register decode: mask, per-source reset control, clear strobes and read mux.
module irq_agg_regs
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [REG_AW-1:0]  addr_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    input  logic [NUM_SRC-1:0] flags_i,
    output logic [NUM_SRC-1:0] mask_o,
    output logic [NUM_SRC-1:0] rstc_o,
    output logic [NUM_SRC-1:0] clr_o,
    output logic [NUM_SRC-1:0] rdata_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] mask;
        logic [NUM_SRC-1:0] rstc;
    } regs_t;

    regs_t    rg_d, rg_q;
    reg_sel_e sel;

    assign sel = reg_sel_e'(addr_i);

    always_comb begin
        rg_d  = rg_q;
        clr_o = '0;
        if (wr_i) begin
            unique case (sel)
                SEL_FLAGS: clr_o   = wdata_i;
                SEL_MASK:  rg_d.mask = wdata_i;
                SEL_RSTC:  rg_d.rstc = wdata_i;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q.mask <= '0;
            rg_q.rstc <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_FLAGS: rdata_o = flags_i;
            SEL_MASK:  rdata_o = rg_q.mask;
            SEL_RSTC:  rdata_o = rg_q.rstc;
            default:   rdata_o = '0;
        endcase
    end

    assign mask_o = rg_q.mask;
    assign rstc_o = rg_q.rstc;

endmodule

// File: rtl/irq_aggregator.sv
`timescale 1ns/1ps
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_irq_n,
    input  logic               bus_wr,
    input  logic [REG_AW-1:0]  bus_addr,
    input  logic [NUM_SRC-1:0] bus_wdata,
    output logic [NUM_SRC-1:0] bus_rdata,
    output logic               host_irq,
    output logic [NUM_SRC-1:0] src_rst
);

    logic [NUM_SRC-1:0] edge_w;
    logic [NUM_SRC-1:0] clr_w;
    logic [NUM_SRC-1:0] flags_w;
    logic [NUM_SRC-1:0] mask_w;

    irq_agg_sync #(.NUM_SRC(NUM_SRC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_n_i (src_irq_n),
        .fall_o  (edge_w)
    );

    irq_agg_flags #(.NUM_SRC(NUM_SRC)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (edge_w),
        .clr_i   (clr_w),
        .flags_o (flags_w)
    );

    irq_agg_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .flags_i (flags_w),
        .mask_o  (mask_w),
        .rstc_o  (src_rst),
        .clr_o   (clr_w),
        .rdata_o (bus_rdata)
    );

    assign host_irq = |(flags_w & mask_w);

endmodule

// File: rtl/irq_aggregator_chk.sv
`timescale 1ns/1ps
module irq_aggregator_chk
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic [REG_AW-1:0]  bus_addr,
    input logic [NUM_SRC-1:0] bus_wdata,
    input logic               host_irq,
    input logic [NUM_SRC-1:0] src_rst,
    input logic [NUM_SRC-1:0] flags_q,
    input logic [NUM_SRC-1:0] mask_q,
    input logic [NUM_SRC-1:0] set_vec
);

    // R2: a flag bit only rises after a detected edge for that source
    a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_q & ~$past(flags_q) & ~$past(set_vec)) == '0));

    // R4: a detected edge always leaves the flag set, clear or not
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));

    // R3: a clear write removes every named bit that had no new request
    a_r3_clear_applies: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0) |=>
            ((flags_q & $past(bus_wdata) & ~$past(set_vec)) == '0));

    // R5: with no enabled flag the host line stays low
    a_r5_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_q & mask_q) == '0) |-> !host_irq);

    // R7: reset-control write reaches the per-source reset pins
    a_r7_rst_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2) |=> (src_rst == $past(bus_wdata)));

    // R9: a held-low input yields a single-cycle edge pulse only
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((set_vec & $past(set_vec)) == '0));

    // R8: a write to the unused offset leaves mask and reset control alone
    a_r8_unused_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd3) |=> ($stable(mask_q) && $stable(src_rst)));

endmodule

bind irq_aggregator irq_aggregator_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .host_irq  (host_irq),
    .src_rst   (src_rst),
    .flags_q   (flags_w),
    .mask_q    (mask_w),
    .set_vec   (edge_w)
);

// File: tb/tb_irq_aggregator.sv
`timescale 1ns/1ps
module tb_irq_aggregator;

    localparam int N = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src_irq_n = '1;
    logic         bus_wr = 1'b0;
    logic [1:0]   bus_addr = '0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic         host_irq;
    logic [N-1:0] src_rst;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    irq_aggregator #(.NUM_SRC(N)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_irq_n (src_irq_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .host_irq  (host_irq),
        .src_rst   (src_rst)
    );

    // op: 0 write, 1 drive sources and wait 3 clocks, 2 read and compare, 3 compare host_irq
    typedef struct packed {
        logic [1:0]   op;
        logic [1:0]   addr;
        logic [N-1:0] data;
        logic [N-1:0] exp;
        logic [3:0]   req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 2'd0, 12'hFFE, 12'h000, 4'd2},   // R2 source 0 falls
        '{2'd2, 2'd0, 12'h000, 12'h001, 4'd2},   // R2
        '{2'd3, 2'd0, 12'h000, 12'h000, 4'd5},   // R5 mask zero
        '{2'd0, 2'd1, 12'h001, 12'h000, 4'd0},
        '{2'd2, 2'd1, 12'h000, 12'h001, 4'd6},   // R6
        '{2'd3, 2'd0, 12'h000, 12'h001, 4'd5},   // R5 enabled
        '{2'd0, 2'd1, 12'hFFF, 12'h000, 4'd0},
        '{2'd2, 2'd1, 12'h000, 12'hFFF, 4'd6},   // R6
        '{2'd1, 2'd0, 12'hFFF, 12'h000, 4'd10},  // R10 rising edge
        '{2'd2, 2'd0, 12'h000, 12'h001, 4'd10},  // R10
        '{2'd1, 2'd0, 12'h7F6, 12'h000, 4'd2},   // R2 bits 0,3,11 fall
        '{2'd2, 2'd0, 12'h000, 12'h809, 4'd2},   // R2
        '{2'd0, 2'd0, 12'h008, 12'h000, 4'd0},
        '{2'd2, 2'd0, 12'h000, 12'h801, 4'd3},   // R3
        '{2'd0, 2'd0, 12'h000, 12'h000, 4'd0},
        '{2'd2, 2'd0, 12'h000, 12'h801, 4'd3},   // R3 zero bits keep flags
        '{2'd0, 2'd0, 12'h801, 12'h000, 4'd0},
        '{2'd2, 2'd0, 12'h000, 12'h000, 4'd3},   // R3
        '{2'd3, 2'd0, 12'h000, 12'h000, 4'd5},   // R5 no flags
        '{2'd1, 2'd0, 12'h7F6, 12'h000, 4'd9},   // R9 held low
        '{2'd2, 2'd0, 12'h000, 12'h000, 4'd9},   // R9
        '{2'd0, 2'd2, 12'hA5A, 12'h000, 4'd0},
        '{2'd2, 2'd2, 12'h000, 12'hA5A, 4'd7},   // R7
        '{2'd0, 2'd3, 12'hFFF, 12'h000, 4'd0},
        '{2'd2, 2'd3, 12'h000, 12'h000, 4'd8},   // R8
        '{2'd2, 2'd1, 12'h000, 12'hFFF, 4'd8},   // R8 mask untouched
        '{2'd2, 2'd2, 12'h000, 12'hA5A, 4'd8}    // R8 reset control untouched
    };

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%03h expected=%03h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic do_read(input logic [1:0] a, output logic [N-1:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic drive_src(input logic [N-1:0] v);
        @(negedge clk);
        src_irq_n = v;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        logic [N-1:0] rd;
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 host_irq in reset", {11'd0, host_irq}, '0);
        check("R1 src_rst in reset", src_rst, '0);
        rst_n = 1'b1;
        do_read(2'd0, rd); check("R1 flags", rd, '0);
        do_read(2'd1, rd); check("R1 mask", rd, '0);
        do_read(2'd2, rd); check("R1 reset control", rd, '0);

        foreach (VECS[i]) begin
            case (VECS[i].op)
                2'd0: do_write(VECS[i].addr, VECS[i].data);
                2'd1: drive_src(VECS[i].data);
                2'd2: begin
                    do_read(VECS[i].addr, rd);
                    check($sformatf("R%0d vector %0d", VECS[i].req, i), rd, VECS[i].exp);
                end
                default: begin
                    @(negedge clk); #1;
                    check($sformatf("R%0d vector %0d host_irq", VECS[i].req, i),
                          {11'd0, host_irq}, VECS[i].exp);
                end
            endcase
        end

        // R7 reset pins follow the control register
        check("R7 src_rst port", src_rst, 12'hA5A);

        // R4 new request on bit 0 coincides with clear of bits 0 and 1
        drive_src(12'hFFF);
        drive_src(12'hFFD);
        drive_src(12'hFFF);
        do_read(2'd0, rd); check("R4 setup bit 1", rd, 12'h002);
        @(negedge clk);
        src_irq_n = 12'hFFE;
        @(negedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 12'h003;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        do_read(2'd0, rd); check("R4 set wins, other bit cleared", rd, 12'h001);
        #1 check("R5 host_irq with enabled flag", {11'd0, host_irq}, 12'h001);

        // R1 reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        src_irq_n = '1;
        #1;
        check("R1 mid-run host_irq", {11'd0, host_irq}, '0);
        check("R1 mid-run src_rst", src_rst, '0);
        check("R1 mid-run flags", bus_rdata, '0);
        @(negedge clk);
        rst_n = 1'b1;
        do_read(2'd1, rd); check("R1 mid-run mask", rd, '0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule